// File: doc/BRIEF.md
# Fractional-Position Pixel Interpolator

This block turns a stream of source pixel windows into rows of interpolated 8-bit pixels. Each row sits at a quarter, half or three-quarter pixel position between source samples. Every accepted window holds eleven consecutive source pixels along one axis, so one row of eight output pixels can be computed. The eleven pixels are a row for horizontal filtering, or a column slice gathered by the caller for vertical filtering. Each output pixel combines four neighbouring samples through a fixed set of weights. A rounding constant is then added, and the result is shifted right arithmetically and saturated to 8 bits.

Three controls travel with each window. The first is the axis, which only changes how the rounding bit is applied. The second is the frame rounding bit. The third is a blend flag: when it is set, the result is averaged with the pixel already held at the destination, and the caller supplies those eight destination pixels alongside the window. Eight accepted windows form one 8x8 block, and the last row of each block is flagged. A window that asks for the integer position is refused: an error pulse is raised, no output row is produced, and the window is not counted as a row.

Top module: `subpel_filter`

## Requirements
- R1: Mode 2 (half position) gives each output pixel j the value (-p[j] + 9*p[j+1] + 9*p[j+2] - p[j+3] + 8 - r) >>> 4. Window pixel k occupies bits [8k+7:8k] of `in_win`, and k = 0 is the sample one position before output j = 0.
- R2: Mode 1 (quarter position) gives (-4*p[j] + 53*p[j+1] + 18*p[j+2] - 3*p[j+3] + 32 - r) >>> 6.
- R3: Mode 3 (three-quarter position) uses the mirrored weights: (-3*p[j] + 18*p[j+1] + 53*p[j+2] - 4*p[j+3] + 32 - r) >>> 6.
- R4: The shifted sum saturates to the range 0..255. Negative values become 0 and values above 255 become 255.
- R5: The rounding value r is 1 - `in_rnd` when `in_vert` = 1 (vertical axis), and `in_rnd` when `in_vert` = 0 (horizontal axis).
- R6: When `in_avg` = 1, output pixel j is (f + d[j] + 1) >> 1, where f is the filtered pixel and d[j] is bits [8j+7:8j] of `in_dst`. When `in_avg` = 0, the output is f.
- R7: A window accepted with mode 0 sets `err` high for exactly the following cycle. It produces no output row and does not advance the row count.
- R8: Each window accepted with a nonzero mode yields exactly one output row, valid on the cycle after acceptance. `out_last` is set on rows 8, 16, and so on, counting only accepted nonzero-mode windows since reset.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pix` and `out_last` hold steady. `in_ready` is high exactly when no output row is waiting or the waiting row is taken in the same cycle.
- R10: After reset, `out_valid` and `err` are low, `in_ready` is high, and the row count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and controls are present |
| in_ready | output | 1 | Block can take a window this cycle |
| in_win | input | 88 | Eleven source pixels, pixel k at bits [8k+7:8k] |
| in_dst | input | 64 | Existing destination pixels for blending |
| in_mode | input | 2 | 1 quarter, 2 half, 3 three-quarter, 0 refused |
| in_vert | input | 1 | 1 vertical axis, 0 horizontal axis |
| in_rnd | input | 1 | Frame rounding bit |
| in_avg | input | 1 | 1 blends with destination, 0 writes directly |
| out_valid | output | 1 | Output row is present |
| out_ready | input | 1 | Consumer takes the row this cycle |
| out_pix | output | 64 | Eight output pixels, pixel j at bits [8j+7:8j] |
| out_last | output | 1 | Row closes an 8-row block |
| err | output | 1 | One-cycle pulse after a mode-0 window |

## Verification
All 24 combinations of mode, axis, rounding bit and blend flag are run over random windows. A swapped weight set, an inverted rounding rule or a missing blend therefore shows up as a pixel mismatch for the one combination it affects. Flat-extreme windows (a bright centre with dark edges, and the reverse) drive the sum past both saturation limits, which separates correct clamping from wrap-around. Mode-0 windows are inserted in the middle of blocks, so a row count that advances on refused windows moves the last-row flag. Random stalls on the output side show whether a held row changes or a row is dropped.

// File: rtl/subpel_filter.sv
module subpel_filter #(
  parameter int COLS = 8,
  parameter int ROWS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [(COLS+3)*8-1:0] in_win,
  input  logic [COLS*8-1:0]     in_dst,
  input  logic [1:0]            in_mode,
  input  logic                  in_vert,
  input  logic                  in_rnd,
  input  logic                  in_avg,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [COLS*8-1:0]     out_pix,
  output logic                  out_last,
  output logic                  err
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [RW-1:0]       row;
  logic [COLS*8-1:0]   res;
  logic                take, rv;
  logic signed [15:0]  rv16;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign rv       = in_vert ? ~in_rnd : in_rnd;
  assign rv16     = signed'({15'd0, rv});

  for (genvar g = 0; g < COLS; g++) begin : g_col
    logic signed [15:0] a, b, c, d, acc, sh;
    logic [7:0]         clip, old;
    logic [8:0]         blend;

    assign a   = signed'({8'd0, in_win[8*g      +: 8]});
    assign b   = signed'({8'd0, in_win[8*(g+1)  +: 8]});
    assign c   = signed'({8'd0, in_win[8*(g+2)  +: 8]});
    assign d   = signed'({8'd0, in_win[8*(g+3)  +: 8]});
    assign old = in_dst[8*g +: 8];

    always_comb begin
      case (in_mode)
        2'd1:    acc = 16'sd53*b + 16'sd18*c - 16'sd4*a - 16'sd3*d + 16'sd32 - rv16;
        2'd2:    acc = 16'sd9*(b + c) - a - d + 16'sd8 - rv16;
        2'd3:    acc = 16'sd18*b + 16'sd53*c - 16'sd3*a - 16'sd4*d + 16'sd32 - rv16;
        default: acc = '0;
      endcase
      sh = (in_mode == 2'd2) ? (acc >>> 4) : (acc >>> 6);
      if (sh < 0)              clip = 8'd0;
      else if (sh > 16'sd255)  clip = 8'd255;
      else                     clip = sh[7:0];
    end

    assign blend = {1'b0, clip} + {1'b0, old} + 9'd1;
    assign res[8*g +: 8] = in_avg ? blend[8:1] : clip;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
      err       <= 1'b0;
      row       <= '0;
    end else begin
      err <= take && (in_mode == 2'd0);
      if (take && in_mode != 2'd0) begin
        out_valid <= 1'b1;
        out_pix   <= res;
        out_last  <= (row == RW'(ROWS-1));
        row       <= (row == RW'(ROWS-1)) ? '0 : row + 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_last));

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'd0 |=> err && !out_valid);

  assert_err_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_mode == 2'd0));

  assert_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode != 2'd0 |=> out_valid);

  assert_last_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !(out_valid && out_last));
endmodule

// File: tb/subpel_filter_test.sv
module subpel_filter_test;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_vert = 0, in_rnd = 0, in_avg = 0, out_ready = 0;
  logic [87:0] in_win = '0;
  logic [63:0] in_dst = '0;
  logic [1:0]  in_mode = 2'd1;
  logic        in_ready, out_valid, out_last, err;
  logic [63:0] out_pix;

  subpel_filter uut (.clk, .rst_n, .in_valid, .in_ready, .in_win, .in_dst, .in_mode,
                     .in_vert, .in_rnd, .in_avg, .out_valid, .out_ready, .out_pix,
                     .out_last, .err);

  always #5 clk = ~clk;

  int          checks = 0, fails = 0, rows_sent = 0;
  bit          done = 0, drained = 0, stall_out = 1;
  logic [63:0] q_pix[$];
  logic        q_last[$];
  string       q_tag[$];

  function automatic logic [7:0] model(int a, int b, int c, int d, int mode,
                                       bit vert, bit rnd, bit avg, int old);
    int r, s, v;
    r = vert ? 1 - rnd : rnd;
    case (mode)
      1:       begin s = -4*a + 53*b + 18*c - 3*d + 32 - r; v = s >>> 6; end
      2:       begin s = -a + 9*b + 9*c - d + 8 - r;        v = s >>> 4; end
      default: begin s = -3*a + 18*b + 53*c - 4*d + 32 - r; v = s >>> 6; end
    endcase
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    if (avg) v = (v + old + 1) >> 1;
    return v[7:0];
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [87:0] w, logic [63:0] dd, int mode, bit vert, bit rnd,
                      bit avg, string tag);
    logic [63:0] e;
    for (int j = 0; j < 8; j++)
      e[8*j +: 8] = model(w[8*j +: 8], w[8*(j+1) +: 8], w[8*(j+2) +: 8], w[8*(j+3) +: 8],
                          mode, vert, rnd, avg, dd[8*j +: 8]);
    in_win = w; in_dst = dd; in_mode = mode[1:0]; in_vert = vert; in_rnd = rnd;
    in_avg = avg; in_valid = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    if (mode != 0) begin
      q_pix.push_back(e);
      q_last.push_back((rows_sent % 8) == 7);
      q_tag.push_back(tag);
      rows_sent++;
    end
    @(posedge clk); #1;
    in_valid = 0;
    if (mode == 0) check(err && !out_valid, "R7", {62'd0, err, out_valid}, 64'd2);
  endtask

  function automatic logic [87:0] rnd_win();
    return {$urandom, $urandom, $urandom};
  endfunction

  always @(negedge clk) begin
    logic [63:0] prev_pix;
    bit          held;
    if (rst_n) begin
      if (held) check(out_valid && out_pix == prev_pix, "R9", out_pix, prev_pix);
      if (out_valid && out_ready) begin
        if (q_pix.size() == 0) check(0, "R8", out_pix, 64'd0);
        else begin
          logic [63:0] ep;
          logic        el;
          string       t;
          ep = q_pix.pop_front(); el = q_last.pop_front(); t = q_tag.pop_front();
          check(out_pix == ep, t, out_pix, ep);
          check(out_last == el, "R8", {63'd0, out_last}, {63'd0, el});
        end
      end
      held = out_valid && !out_ready;
      prev_pix = out_pix;
    end else held = 0;
  end

  always @(posedge clk) begin
    #1;
    out_ready = stall_out ? ($urandom % 4 != 0) : 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !err && in_ready, "R10", {61'd0, out_valid, err, in_ready}, 64'd1);
    rst_n = 1;
    for (int m = 1; m <= 3; m++)
      for (int v = 0; v < 2; v++)
        for (int r = 0; r < 2; r++)
          for (int a = 0; a < 2; a++)
            for (int k = 0; k < 8; k++) begin
              if (a) tag = "R6";
              else if (v) tag = "R5";
              else tag = (m == 1) ? "R2" : (m == 2) ? "R1" : "R3";
              send(rnd_win(), {$urandom, $urandom}, m, v[0], r[0], a[0], tag);
              if (k == 3 && r == 1) send(rnd_win(), '0, 0, v[0], 1'b0, 1'b0, "R7");
            end
    for (int m = 1; m <= 3; m++) begin
      send({11{8'h00}} | {8'h00, {4{8'h00}}, {3{8'hff}}, 8'h00, 8'h00, 8'h00}, '0, m, 0, 0, 0, "R4");
      send({8'hff, 8'hff, {3{8'hff}}, {3{8'h00}}, 8'hff, 8'hff, 8'hff}, '0, m, 1, 1, 0, "R4");
      send({{4{8'h00}}, {3{8'hff}}, {4{8'h00}}}, '0, m, 0, 1, 0, "R4");
      send({{4{8'hff}}, {3{8'h00}}, {4{8'hff}}}, '0, m, 1, 0, 1, "R4");
      send({11{8'hff}}, {8{8'hff}}, m, 0, 0, 1, "R4");
    end
    send(rnd_win(), '0, 0, 1, 1, 1, "R7");
    stall_out = 0;
    while (q_pix.size() != 0 || out_valid) @(posedge clk);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule